// File: doc/BRIEF.md
# Frame Ring Pointer Tracker

This block keeps the occupancy bookkeeping for a circular buffer whose unit is a 32-byte frame. The ring length is a power of two (128 frames by default) and every pointer wraps modulo that length. Each side of the ring holds two pointers. The producer side has a committed pointer and an allocated pointer. The consumer side has a discarded pointer and a peeked pointer. Because each side has two pointers, a 16-frame region can be reserved before its data is valid, or handed out before it is released.

Two command styles are offered. A bulk write or bulk read asks for a number of frames and receives a grant in the same cycle. The grant is clipped by what is available and by the distance to the wrap point, and it moves both pointers of that side together. Split multiframe commands work on exactly 16 frames. A prepare reserves space and a later commit makes it valid. A peek hands out data and a later discard frees it. A flush command empties the consumer side down to the last multiframe boundary below the committed pointer.

Each granted operation returns the buffer offset, which is the base frame plus the pointer, or the multiframe index, which is that offset divided by 16. The block also reports four level counts. Data storage and the data mover are outside the block.

Top module: `frame_ring_tracker`

## Requirements
- R1: After reset all four pointers are zero, so the allocated, valid and unseen levels read 0 and the free level reads RING_FRAMES-1.
- R2: The levels are taken modulo the ring length. allocated = alloc_ptr - disc_ptr, valid = commit_ptr - disc_ptr, unseen = commit_ptr - peek_ptr, free = disc_ptr - alloc_ptr - 1.
- R3: A bulk write grants min(requested, free, RING_FRAMES - commit_ptr) in the same cycle. It reports wr_ofs_o = (BASE_FRAME + commit_ptr) mod 2^OFS_W. At the clock edge both producer pointers become commit_ptr + grant.
- R4: A bulk read grants min(requested, unseen, RING_FRAMES - peek_ptr) in the same cycle. It reports rd_ofs_o = (BASE_FRAME + peek_ptr) mod 2^OFS_W. At the clock edge both consumer pointers become peek_ptr + grant.
- R5: A prepare succeeds only when free >= 16. On success it reports prep_mf_o = ((BASE_FRAME + alloc_ptr) mod 2^OFS_W) >> 4 and advances alloc_ptr by 16. A refused prepare changes nothing.
- R6: A commit advances commit_ptr by 16, so valid and unseen each rise by 16.
- R7: A peek succeeds only when unseen >= 16. On success it reports peek_mf_o = ((BASE_FRAME + peek_ptr) mod 2^OFS_W) >> 4 and advances peek_ptr by 16.
- R8: A discard advances disc_ptr by 16, so valid and allocated each fall by 16 and free rises by 16.
- R9: A flush sets disc_ptr and peek_ptr to commit_ptr with its low 4 bits cleared. Afterwards valid equals unseen equals commit_ptr mod 16.
- R10: A flush takes priority. In its cycle every grant reads 0, both ok flags read 0, and no other command moves a pointer.
- R11: A bulk request takes priority over the split commands on its own side. While wr_req_i is high, prepare and commit are ignored. While rd_req_i is high, peek and discard are ignored.
- R12: With no request on a side, that side's grant reads 0 and its ok flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the consumer side to the last multiframe boundary |
| wr_req_i | input | 1 | Bulk write request |
| wr_cnt_i | input | PW+1 | Frames requested for the bulk write |
| wr_grant_o | output | PW+1 | Frames granted for the bulk write |
| wr_ofs_o | output | OFS_W | Buffer frame offset for the bulk write |
| rd_req_i | input | 1 | Bulk read request |
| rd_cnt_i | input | PW+1 | Frames requested for the bulk read |
| rd_grant_o | output | PW+1 | Frames granted for the bulk read |
| rd_ofs_o | output | OFS_W | Buffer frame offset for the bulk read |
| prep_req_i | input | 1 | Reserve one 16-frame region |
| prep_ok_o | output | 1 | Reservation granted |
| prep_mf_o | output | OFS_W-4 | Multiframe index of the reserved region |
| commit_i | input | 1 | Mark one reserved region valid |
| peek_req_i | input | 1 | Hand out one 16-frame region |
| peek_ok_o | output | 1 | Hand-out granted |
| peek_mf_o | output | OFS_W-4 | Multiframe index of the handed-out region |
| discard_i | input | 1 | Release one handed-out region |
| alloc_lvl_o | output | PW | Allocated frame count |
| valid_lvl_o | output | PW | Valid frame count |
| unseen_lvl_o | output | PW | Valid frames not yet handed out |
| free_lvl_o | output | PW | Frames not allocated |

## Verification
Some commands can fall in the same cycle. A flush can meet any bulk or split command, and a bulk request can meet the split commands of its own side. The random phase raises all seven command inputs on independent odds, so these overlaps occur often. Directed cycles also assert flush together with every other command. The bench judges each overlap against its own pointer model. The losing commands must show zero grants and cleared ok flags in that cycle. The levels after the edge must match a model in which only the winning command moved a pointer.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef struct packed {
    logic set;
    logic step_lead;
    logic step_trail;
  } pp_cmd_t;

  localparam int unsigned SIDE_WR = 0;
  localparam int unsigned SIDE_RD = 1;
endpackage

// File: rtl/frt_ptr_pair.sv
module frt_ptr_pair
  import frt_pkg::*;
#(
  parameter int unsigned PW   = 7,
  parameter int unsigned STEP = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pp_cmd_t       cmd_i,
  input  logic [PW-1:0] set_val_i,
  output logic [PW-1:0] lead_o,
  output logic [PW-1:0] trail_o
);
  localparam logic [PW-1:0] STEP_P = PW'(STEP);

  logic [PW-1:0] lead_q, trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_q  <= '0;
      trail_q <= '0;
    end else if (cmd_i.set) begin
      lead_q  <= set_val_i;
      trail_q <= set_val_i;
    end else begin
      if (cmd_i.step_lead)  lead_q  <= lead_q + STEP_P;
      if (cmd_i.step_trail) trail_q <= trail_q + STEP_P;
    end
  end

  assign lead_o  = lead_q;
  assign trail_o = trail_q;
endmodule

// File: rtl/frt_grant.sv
module frt_grant #(
  parameter int unsigned PW = 7
) (
  input  logic          req_i,
  input  logic [PW:0]   cnt_i,
  input  logic [PW-1:0] avail_i,
  input  logic [PW-1:0] ptr_i,
  output logic [PW:0]   grant_o
);
  localparam logic [PW:0] RING_P = (PW+1)'(1) << PW;

  logic [PW:0] room, avail_w, m0, m1;

  always_comb begin
    room    = RING_P - {1'b0, ptr_i};
    avail_w = {1'b0, avail_i};
    m0      = (cnt_i < avail_w) ? cnt_i : avail_w;
    m1      = (m0 < room) ? m0 : room;
    grant_o = req_i ? m1 : '0;
  end
endmodule

// File: rtl/frt_levels.sv
module frt_levels #(
  parameter int unsigned PW = 7
) (
  input  logic [PW-1:0] alloc_ptr_i,
  input  logic [PW-1:0] commit_ptr_i,
  input  logic [PW-1:0] disc_ptr_i,
  input  logic [PW-1:0] peek_ptr_i,
  output logic [PW-1:0] alloc_lvl_o,
  output logic [PW-1:0] valid_lvl_o,
  output logic [PW-1:0] unseen_lvl_o,
  output logic [PW-1:0] free_lvl_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  always_comb begin
    alloc_lvl_o  = alloc_ptr_i - disc_ptr_i;
    valid_lvl_o  = commit_ptr_i - disc_ptr_i;
    unseen_lvl_o = commit_ptr_i - peek_ptr_i;
    free_lvl_o   = disc_ptr_i - alloc_ptr_i - ONE;
  end
endmodule

// File: rtl/frame_ring_tracker.sv
module frame_ring_tracker
  import frt_pkg::*;
#(
  parameter int unsigned RING_FRAMES = 128,
  parameter int unsigned MF_FRAMES   = 16,
  parameter int unsigned BASE_FRAME  = 0,
  parameter int unsigned OFS_W       = 8,
  localparam int unsigned PW         = $clog2(RING_FRAMES),
  localparam int unsigned MF_SHIFT   = $clog2(MF_FRAMES),
  localparam int unsigned MF_W       = OFS_W - MF_SHIFT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            wr_req_i,
  input  logic [PW:0]     wr_cnt_i,
  output logic [PW:0]     wr_grant_o,
  output logic [OFS_W-1:0] wr_ofs_o,
  input  logic            rd_req_i,
  input  logic [PW:0]     rd_cnt_i,
  output logic [PW:0]     rd_grant_o,
  output logic [OFS_W-1:0] rd_ofs_o,
  input  logic            prep_req_i,
  output logic            prep_ok_o,
  output logic [MF_W-1:0] prep_mf_o,
  input  logic            commit_i,
  input  logic            peek_req_i,
  output logic            peek_ok_o,
  output logic [MF_W-1:0] peek_mf_o,
  input  logic            discard_i,
  output logic [PW-1:0]   alloc_lvl_o,
  output logic [PW-1:0]   valid_lvl_o,
  output logic [PW-1:0]   unseen_lvl_o,
  output logic [PW-1:0]   free_lvl_o
);
  localparam logic [PW-1:0]    MF_P    = PW'(MF_FRAMES);
  localparam logic [PW-1:0]    MF_MASK = ~PW'(MF_FRAMES - 1);
  localparam logic [OFS_W-1:0] BASE_P  = OFS_W'(BASE_FRAME);

  logic [PW-1:0] alloc_ptr, commit_ptr, disc_ptr, peek_ptr;
  logic [PW-1:0] free_lvl, unseen_lvl;

  // per-side arrays: index SIDE_WR / SIDE_RD
  logic [1:0]    side_req;
  logic [PW:0]   side_cnt   [2];
  logic [PW-1:0] side_avail [2];
  logic [PW-1:0] side_base  [2];
  logic [PW:0]   side_grant [2];

  pp_cmd_t       wr_cmd, rd_cmd;
  logic [PW-1:0] wr_set_val, rd_set_val;
  logic          prep_ok, peek_ok, commit_en, discard_en;
  logic [OFS_W-1:0] prep_ofs, peek_ofs;

  frt_levels #(.PW(PW)) u_levels (
    .alloc_ptr_i  (alloc_ptr),
    .commit_ptr_i (commit_ptr),
    .disc_ptr_i   (disc_ptr),
    .peek_ptr_i   (peek_ptr),
    .alloc_lvl_o  (alloc_lvl_o),
    .valid_lvl_o  (valid_lvl_o),
    .unseen_lvl_o (unseen_lvl),
    .free_lvl_o   (free_lvl)
  );

  assign unseen_lvl_o = unseen_lvl;
  assign free_lvl_o   = free_lvl;

  always_comb begin
    side_req[SIDE_WR]   = wr_req_i & ~flush_i;
    side_cnt[SIDE_WR]   = wr_cnt_i;
    side_avail[SIDE_WR] = free_lvl;
    side_base[SIDE_WR]  = commit_ptr;
    side_req[SIDE_RD]   = rd_req_i & ~flush_i;
    side_cnt[SIDE_RD]   = rd_cnt_i;
    side_avail[SIDE_RD] = unseen_lvl;
    side_base[SIDE_RD]  = peek_ptr;
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    frt_grant #(.PW(PW)) u_grant (
      .req_i   (side_req[s]),
      .cnt_i   (side_cnt[s]),
      .avail_i (side_avail[s]),
      .ptr_i   (side_base[s]),
      .grant_o (side_grant[s])
    );
  end

  assign wr_grant_o = side_grant[SIDE_WR];
  assign rd_grant_o = side_grant[SIDE_RD];
  assign wr_ofs_o   = BASE_P + OFS_W'(commit_ptr);
  assign rd_ofs_o   = BASE_P + OFS_W'(peek_ptr);

  // flush beats everything; bulk beats split on its own side
  always_comb begin
    prep_ok    = prep_req_i & ~flush_i & ~wr_req_i & (free_lvl >= MF_P);
    commit_en  = commit_i   & ~flush_i & ~wr_req_i;
    peek_ok    = peek_req_i & ~flush_i & ~rd_req_i & (unseen_lvl >= MF_P);
    discard_en = discard_i  & ~flush_i & ~rd_req_i;

    wr_cmd.set        = side_req[SIDE_WR];
    wr_cmd.step_lead  = prep_ok;
    wr_cmd.step_trail = commit_en;
    wr_set_val        = commit_ptr + side_grant[SIDE_WR][PW-1:0];

    rd_cmd.set        = flush_i | side_req[SIDE_RD];
    rd_cmd.step_lead  = peek_ok;
    rd_cmd.step_trail = discard_en;
    rd_set_val        = flush_i ? (commit_ptr & MF_MASK)
                                : (peek_ptr + side_grant[SIDE_RD][PW-1:0]);
  end

  frt_ptr_pair #(.PW(PW), .STEP(MF_FRAMES)) u_wr_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (wr_cmd),
    .set_val_i (wr_set_val),
    .lead_o    (alloc_ptr),
    .trail_o   (commit_ptr)
  );

  frt_ptr_pair #(.PW(PW), .STEP(MF_FRAMES)) u_rd_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (rd_cmd),
    .set_val_i (rd_set_val),
    .lead_o    (peek_ptr),
    .trail_o   (disc_ptr)
  );

  assign prep_ofs  = BASE_P + OFS_W'(alloc_ptr);
  assign peek_ofs  = BASE_P + OFS_W'(peek_ptr);
  assign prep_ok_o = prep_ok;
  assign peek_ok_o = peek_ok;
  assign prep_mf_o = prep_ofs[OFS_W-1:MF_SHIFT];
  assign peek_mf_o = peek_ofs[OFS_W-1:MF_SHIFT];
endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
  parameter int unsigned PW        = 7,
  parameter int unsigned MF_FRAMES = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          flush_i,
  input logic          wr_req_i,
  input logic [PW:0]   wr_cnt_i,
  input logic [PW:0]   wr_grant_o,
  input logic          rd_req_i,
  input logic [PW:0]   rd_cnt_i,
  input logic [PW:0]   rd_grant_o,
  input logic          prep_req_i,
  input logic          prep_ok_o,
  input logic          commit_i,
  input logic          peek_req_i,
  input logic          peek_ok_o,
  input logic          discard_i,
  input logic [PW-1:0] valid_lvl_o,
  input logic [PW-1:0] unseen_lvl_o,
  input logic [PW-1:0] free_lvl_o
);
  localparam logic [PW-1:0] MF_P = PW'(MF_FRAMES);

  a_r3_wr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_grant_o <= {1'b0, free_lvl_o}) && (wr_grant_o <= wr_cnt_i));

  a_r4_rd_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_grant_o <= {1'b0, unseen_lvl_o}) && (rd_grant_o <= rd_cnt_i));

  a_r5_prep_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prep_ok_o |-> (free_lvl_o >= MF_P));

  a_r7_peek_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peek_ok_o |-> (unseen_lvl_o >= MF_P));

  a_r6_commit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !flush_i && !wr_req_i && !rd_req_i && !discard_i)
      |=> (valid_lvl_o == PW'($past(valid_lvl_o) + MF_P)));

  a_r9_flush_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ((valid_lvl_o == unseen_lvl_o) && (unseen_lvl_o < MF_P)));

  a_r10_flush_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> ((wr_grant_o == '0) && (rd_grant_o == '0) && !prep_ok_o && !peek_ok_o));

  a_r11_bulk_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i |-> !prep_ok_o) and (rd_req_i |-> !peek_ok_o));

  a_r12_idle_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_req_i |-> (wr_grant_o == '0)) and (!rd_req_i |-> (rd_grant_o == '0))
    and (!prep_req_i |-> !prep_ok_o) and (!peek_req_i |-> !peek_ok_o));
endmodule

bind frame_ring_tracker frt_checker #(.PW(PW), .MF_FRAMES(MF_FRAMES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .wr_req_i     (wr_req_i),
  .wr_cnt_i     (wr_cnt_i),
  .wr_grant_o   (wr_grant_o),
  .rd_req_i     (rd_req_i),
  .rd_cnt_i     (rd_cnt_i),
  .rd_grant_o   (rd_grant_o),
  .prep_req_i   (prep_req_i),
  .prep_ok_o    (prep_ok_o),
  .commit_i     (commit_i),
  .peek_req_i   (peek_req_i),
  .peek_ok_o    (peek_ok_o),
  .discard_i    (discard_i),
  .valid_lvl_o  (valid_lvl_o),
  .unseen_lvl_o (unseen_lvl_o),
  .free_lvl_o   (free_lvl_o)
);

// File: tb/sim_frame_ring_tracker.sv
module sim_frame_ring_tracker;
  localparam int RING  = 128;
  localparam int MF    = 16;
  localparam int BASE  = 32;
  localparam int OFS_W = 8;
  localparam int PW    = 7;
  localparam int M     = RING - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic flush_i = 0, wr_req_i = 0, rd_req_i = 0, prep_req_i = 0;
  logic commit_i = 0, peek_req_i = 0, discard_i = 0;
  logic [PW:0] wr_cnt_i = '0, rd_cnt_i = '0;
  logic [PW:0] wr_grant_o, rd_grant_o;
  logic [OFS_W-1:0] wr_ofs_o, rd_ofs_o;
  logic prep_ok_o, peek_ok_o;
  logic [OFS_W-5:0] prep_mf_o, peek_mf_o;
  logic [PW-1:0] alloc_lvl_o, valid_lvl_o, unseen_lvl_o, free_lvl_o;

  int vectors = 0, errors = 0;
  int m_wa = 0, m_wc = 0, m_rd = 0, m_rp = 0;

  always #2 clk = ~clk;

  frame_ring_tracker #(.RING_FRAMES(RING), .MF_FRAMES(MF), .BASE_FRAME(BASE), .OFS_W(OFS_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .wr_req_i(wr_req_i), .wr_cnt_i(wr_cnt_i), .wr_grant_o(wr_grant_o), .wr_ofs_o(wr_ofs_o),
    .rd_req_i(rd_req_i), .rd_cnt_i(rd_cnt_i), .rd_grant_o(rd_grant_o), .rd_ofs_o(rd_ofs_o),
    .prep_req_i(prep_req_i), .prep_ok_o(prep_ok_o), .prep_mf_o(prep_mf_o), .commit_i(commit_i),
    .peek_req_i(peek_req_i), .peek_ok_o(peek_ok_o), .peek_mf_o(peek_mf_o), .discard_i(discard_i),
    .alloc_lvl_o(alloc_lvl_o), .valid_lvl_o(valid_lvl_o),
    .unseen_lvl_o(unseen_lvl_o), .free_lvl_o(free_lvl_o)
  );

  function automatic int lvl(int a, int b);
    return (a - b) & M;
  endfunction

  function automatic int min3(int a, int b, int c);
    int m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_levels(string tag);
    check({tag, " alloc"},  int'(alloc_lvl_o),  lvl(m_wa, m_rd));
    check({tag, " valid"},  int'(valid_lvl_o),  lvl(m_wc, m_rd));
    check({tag, " unseen"}, int'(unseen_lvl_o), lvl(m_wc, m_rp));
    check({tag, " free"},   int'(free_lvl_o),   (m_rd - m_wa - 1) & M);
  endtask

  task automatic cycle(bit e, bit wr, int wn, bit rd, int rn, bit pr, bit cm, bit pk, bit ds);
    int free, uns, ewg, erg;
    bit epo, epk;
    string t;
    @(negedge clk);
    flush_i = e; wr_req_i = wr; wr_cnt_i = (PW+1)'(wn); rd_req_i = rd; rd_cnt_i = (PW+1)'(rn);
    prep_req_i = pr; commit_i = cm; peek_req_i = pk; discard_i = ds;
    #1;
    free = (m_rd - m_wa - 1) & M;
    uns  = lvl(m_wc, m_rp);
    ewg  = (wr && !e) ? min3(wn, free, RING - m_wc) : 0;
    erg  = (rd && !e) ? min3(rn, uns, RING - m_rp) : 0;
    epo  = pr && !e && !wr && (free >= MF);
    epk  = pk && !e && !rd && (uns >= MF);
    t = e ? "R10 wr grant" : (!wr ? "R12 wr grant" : "R3 wr grant");
    check(t, int'(wr_grant_o), ewg);
    t = e ? "R10 rd grant" : (!rd ? "R12 rd grant" : "R4 rd grant");
    check(t, int'(rd_grant_o), erg);
    t = e ? "R10 prep ok" : (wr ? "R11 prep ok" : (pr ? "R5 prep ok" : "R12 prep ok"));
    check(t, int'(prep_ok_o), int'(epo));
    t = e ? "R10 peek ok" : (rd ? "R11 peek ok" : (pk ? "R7 peek ok" : "R12 peek ok"));
    check(t, int'(peek_ok_o), int'(epk));
    if (wr && !e) check("R3 wr ofs", int'(wr_ofs_o), (BASE + m_wc) & 255);
    if (rd && !e) check("R4 rd ofs", int'(rd_ofs_o), (BASE + m_rp) & 255);
    if (epo) check("R5 prep mf", int'(prep_mf_o), ((BASE + m_wa) & 255) >> 4);
    if (epk) check("R7 peek mf", int'(peek_mf_o), ((BASE + m_rp) & 255) >> 4);
    @(posedge clk);
    if (e) begin
      m_rd = m_wc & ~(MF - 1);
      m_rp = m_rd;
    end else begin
      if (wr) begin m_wc = (m_wc + ewg) & M; m_wa = m_wc; end
      else begin
        if (epo) m_wa = (m_wa + MF) & M;
        if (cm)  m_wc = (m_wc + MF) & M;
      end
      if (rd) begin m_rp = (m_rp + erg) & M; m_rd = m_rp; end
      else begin
        if (epk) m_rp = (m_rp + MF) & M;
        if (ds)  m_rd = (m_rd + MF) & M;
      end
    end
    #1;
    if (e) t = "R9";
    else if (cm && !wr) t = "R6";
    else if (ds && !rd) t = "R8";
    else t = "R2";
    check_levels(t);
  endtask

  bit done = 0;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 check_levels("R1 in reset");
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1 check_levels("R1 after reset");

    // R3 free-limited fill, then R4 drain, then R3 wrap-limited write
    cycle(0, 1, 200, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 200, 0, 0, 0, 0);
    cycle(0, 1, 10, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 5, 0, 0, 0, 0);
    // R5/R6 split write, R7/R8 split read
    for (int i = 0; i < 9; i++) cycle(0, 0, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 0, 0, 1, 1, 0);
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 0, 1, 1, 1, 1);
    // R11 bulk beats split on both sides
    cycle(0, 1, 3, 1, 2, 1, 1, 1, 1);
    // R9 flush at an unaligned commit pointer, R10 flush with everything
    cycle(0, 1, 7, 0, 0, 0, 0, 0, 0);
    cycle(1, 1, 9, 1, 9, 1, 1, 1, 1);
    cycle(1, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 5000; i++)
      cycle(($urandom % 30) == 0, ($urandom % 5) == 0, $urandom % 48,
            ($urandom % 5) == 0, $urandom % 48, ($urandom % 3) == 0,
            ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule